// File: doc/BRIEF.md
# Per-Channel Sync and Blank Level Router

This block sits in a video output pipeline, one stage after the pixel control bits have been serialized. Each cycle it receives one pixel's sync, tri-level sync and blank bits. For each of the three color channels (red, green, blue) it decides which level that channel's converter should produce: video, blank, sync or tri-level sync. The result goes out as a 2-bit level-select code per channel, one cycle after the control bits are captured.

Configuration bits decide which channels carry sync. Each channel has its own enable, so sync can be placed on any mix of red, green and blue, or on none of them. A separate enable adds the tri-level sync behaviour.

The block also produces a digital sync output. This output is delayed by a parameterized number of cycles so that it matches the latency of the full video path. It can therefore drive a monitor's separate sync line and stay aligned with the pixels even when no color channel carries sync.

Top module: `sbr_router`

## Requirements
- R1: While `rst` is high at a rising clock edge, every level code becomes 2'b01 (blank) and `sync_out_n` becomes 1, with the delay line filled with 1.
- R2: Level codes are 2'b00 video, 2'b01 blank, 2'b10 sync and 2'b11 tri-sync. A channel shows 2'b00 when `sync_n`, `trisync_n` and `blank_n` (all active-low) are high.
- R3: When `blank_n` is low, a channel that is not selecting sync or tri-sync shows 2'b01.
- R4: When `sync_n` is low, every channel whose sync enable is set shows 2'b10, whatever the values of `blank_n` and `trisync_n`.
- R5: Each channel has its own sync enable (`cfg_sync_en_r`, `cfg_sync_en_g`, `cfg_sync_en_b`). On a channel whose enable is clear, `sync_n` and `trisync_n` have no effect, so the channel shows only 2'b00 or 2'b01.
- R6: Tri-sync applies when `cfg_trisync_en` is 1, the channel's sync enable is set, `trisync_n` is low and `sync_n` is high. The channel then shows 2'b11, which takes priority over blank.
- R7: When `cfg_trisync_en` is 0, `trisync_n` has no effect on any channel.
- R8: A level code reflects the inputs sampled at the previous rising clock edge (one cycle of latency).
- R9: `sync_out_n` equals the value of `sync_n` sampled PIPE_DEPTH rising edges earlier, counting the edge that captures it, and it does not depend on any enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sync_en_r | input | 1 | Enables sync on the red channel |
| cfg_sync_en_g | input | 1 | Enables sync on the green channel |
| cfg_sync_en_b | input | 1 | Enables sync on the blue channel |
| cfg_trisync_en | input | 1 | Enables tri-level sync |
| sync_n | input | 1 | Pixel sync bit, active-low |
| trisync_n | input | 1 | Pixel tri-sync bit, active-low |
| blank_n | input | 1 | Pixel blank bit, active-low |
| lvl_r | output | 2 | Red channel level code |
| lvl_g | output | 2 | Green channel level code |
| lvl_b | output | 2 | Blue channel level code |
| sync_out_n | output | 1 | Delay-matched digital sync, active-low |

## Verification
The hardest case to reach is the exact alignment of the delayed sync output against an irregular sync pattern. A constant or slowly toggling sync hides an off-by-one error in the delay. The stimulus therefore first fills the delay line with idle values, then drives a pattern with single-cycle pulses and gaps of uneven length. Each output sample is compared against the input recorded PIPE_DEPTH steps earlier. This sequence runs once with every enable clear, which also shows that the output does not depend on the enables. The priority corners, where sync, tri-sync and blank are all active at once, are covered by sweeping all eight enable combinations.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  localparam int NUM_CH = 3;

  typedef enum logic [1:0] {
    LVL_VIDEO = 2'b00,
    LVL_BLANK = 2'b01,
    LVL_SYNC  = 2'b10,
    LVL_TRI   = 2'b11
  } lvl_e;

endpackage

// File: rtl/sbr_chan_sel.sv
module sbr_chan_sel
  import sbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_en,
  input  logic       tri_en,
  input  logic       sync_n,
  input  logic       trisync_n,
  input  logic       blank_n,
  output logic [1:0] lvl_o
);

  lvl_e lvl_d;
  lvl_e lvl_q;

  // Priority order: sync, then tri-sync, then blank, then video.
  always_comb begin
    if (sync_en && !sync_n)
      lvl_d = LVL_SYNC;
    else if (sync_en && tri_en && !trisync_n)
      lvl_d = LVL_TRI;
    else if (!blank_n)
      lvl_d = LVL_BLANK;
    else
      lvl_d = LVL_VIDEO;
  end

  always_ff @(posedge clk) begin
    if (rst)
      lvl_q <= LVL_BLANK;
    else
      lvl_q <= lvl_d;
  end

  assign lvl_o = lvl_q;

endmodule

// File: rtl/sbr_sync_delay.sv
module sbr_sync_delay #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [DEPTH-1:0] sr_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)
          sr_q <= '1;
        else
          sr_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst)
          sr_q <= '1;
        else
          sr_q <= {sr_q[DEPTH-2:0], din};
      end
    end
  endgenerate

  assign dout = sr_q[DEPTH-1];

endmodule

// File: rtl/sbr_router.sv
module sbr_router
  import sbr_pkg::*;
#(
  parameter int PIPE_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_sync_en_r,
  input  logic       cfg_sync_en_g,
  input  logic       cfg_sync_en_b,
  input  logic       cfg_trisync_en,
  input  logic       sync_n,
  input  logic       trisync_n,
  input  logic       blank_n,
  output logic [1:0] lvl_r,
  output logic [1:0] lvl_g,
  output logic [1:0] lvl_b,
  output logic       sync_out_n
);

  logic [NUM_CH-1:0] en_vec;
  logic [1:0]        lvl_vec [NUM_CH];

  // Channel index 0 red, 1 green, 2 blue.
  assign en_vec = {cfg_sync_en_b, cfg_sync_en_g, cfg_sync_en_r};

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      sbr_chan_sel u_sel (
        .clk       (clk),
        .rst       (rst),
        .sync_en   (en_vec[ch]),
        .tri_en    (cfg_trisync_en),
        .sync_n    (sync_n),
        .trisync_n (trisync_n),
        .blank_n   (blank_n),
        .lvl_o     (lvl_vec[ch])
      );
    end
  endgenerate

  assign lvl_r = lvl_vec[0];
  assign lvl_g = lvl_vec[1];
  assign lvl_b = lvl_vec[2];

  sbr_sync_delay #(.DEPTH(PIPE_DEPTH)) u_dly (
    .clk  (clk),
    .rst  (rst),
    .din  (sync_n),
    .dout (sync_out_n)
  );

endmodule

// File: rtl/sbr_router_chk.sv
module sbr_router_chk #(
  parameter int PIPE_DEPTH = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       cfg_sync_en_r,
  input logic       cfg_sync_en_g,
  input logic       cfg_sync_en_b,
  input logic       cfg_trisync_en,
  input logic       sync_n,
  input logic       trisync_n,
  input logic       blank_n,
  input logic [1:0] lvl_r,
  input logic [1:0] lvl_g,
  input logic [1:0] lvl_b,
  input logic       sync_out_n
);

  localparam int CW = $clog2(PIPE_DEPTH + 1) + 1;

  logic [CW-1:0] hi_cnt;
  logic [CW-1:0] lo_cnt;

  // Run-length counters of sync_n since reset, saturating at PIPE_DEPTH.
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      if (sync_n) begin
        lo_cnt <= '0;
        if (hi_cnt != CW'(PIPE_DEPTH)) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt != CW'(PIPE_DEPTH)) lo_cnt <= lo_cnt + 1'b1;
      end
    end
  end

  // R1
  assert_reset_blank_R1: assert property (@(posedge clk)
    rst |=> (lvl_r == 2'b01 && lvl_g == 2'b01 && lvl_b == 2'b01));

  // R2, R8
  assert_video_R2: assert property (@(posedge clk) disable iff (rst)
    (sync_n && trisync_n && blank_n) |=>
      (lvl_r == 2'b00 && lvl_g == 2'b00 && lvl_b == 2'b00));

  // R3
  assert_blank_level_R3: assert property (@(posedge clk) disable iff (rst)
    (!blank_n && sync_n && trisync_n) |=>
      (lvl_r == 2'b01 && lvl_g == 2'b01 && lvl_b == 2'b01));

  // R4
  assert_sync_green_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_sync_en_g && !sync_n) |=> (lvl_g == 2'b10));

  // R5
  assert_no_sync_red_R5: assert property (@(posedge clk) disable iff (rst)
    !cfg_sync_en_r |=> (lvl_r == 2'b00 || lvl_r == 2'b01));

  // R6
  assert_trisync_blue_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_trisync_en && cfg_sync_en_b && sync_n && !trisync_n) |=> (lvl_b == 2'b11));

  // R7
  assert_no_tri_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_trisync_en |=> (lvl_r != 2'b11 && lvl_g != 2'b11 && lvl_b != 2'b11));

  // R9
  assert_sync_out_high_R9: assert property (@(posedge clk) disable iff (rst)
    (hi_cnt == CW'(PIPE_DEPTH)) |-> sync_out_n);

  assert_sync_out_low_R9: assert property (@(posedge clk) disable iff (rst)
    (lo_cnt == CW'(PIPE_DEPTH)) |-> !sync_out_n);

endmodule

bind sbr_router sbr_router_chk #(.PIPE_DEPTH(PIPE_DEPTH)) u_chk (.*);

// File: tb/sbr_router_tb.sv
module sbr_router_tb;

  localparam int PIPE_DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_r = 1'b0, en_g = 1'b0, en_b = 1'b0, tri_en = 1'b0;
  logic s_n = 1'b1, t_n = 1'b1, b_n = 1'b1;
  logic [1:0] lvl_r, lvl_g, lvl_b;
  logic sync_out_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sbr_router #(.PIPE_DEPTH(PIPE_DEPTH)) u_dut (
    .clk(clk), .rst(rst),
    .cfg_sync_en_r(en_r), .cfg_sync_en_g(en_g), .cfg_sync_en_b(en_b),
    .cfg_trisync_en(tri_en),
    .sync_n(s_n), .trisync_n(t_n), .blank_n(b_n),
    .lvl_r(lvl_r), .lvl_g(lvl_g), .lvl_b(lvl_b),
    .sync_out_n(sync_out_n)
  );

  function automatic logic [1:0] exp_lvl(input logic en, input logic te,
                                         input logic sn, input logic tn, input logic bn);
    if (en && !sn)            return 2'b10;
    else if (en && te && !tn) return 2'b11;
    else if (!bn)             return 2'b01;
    else                      return 2'b00;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive at the negedge, let one posedge capture, sample at the next negedge (R8).
  task automatic step(input logic sn, input logic tn, input logic bn);
    s_n = sn; t_n = tn; b_n = bn;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    check({req, " red"},   lvl_r, exp_lvl(en_r, tri_en, s_n, t_n, b_n));
    check({req, " green"}, lvl_g, exp_lvl(en_g, tri_en, s_n, t_n, b_n));
    check({req, " blue"},  lvl_b, exp_lvl(en_b, tri_en, s_n, t_n, b_n));
  endtask

  task automatic t_reset_r1();
    rst = 1'b1;
    step(1'b0, 1'b0, 1'b1);
    check("R1 red", lvl_r, 2'b01);
    check("R1 green", lvl_g, 2'b01);
    check("R1 blue", lvl_b, 2'b01);
    check("R1 sync_out", {1'b0, sync_out_n}, 2'b01);
    rst = 1'b0;
  endtask

  task automatic t_video_blank_r2_r3();
    en_r = 1'b1; en_g = 1'b1; en_b = 1'b1; tri_en = 1'b1;
    step(1'b1, 1'b1, 1'b1); check_all("R2 video");
    step(1'b1, 1'b1, 1'b0); check_all("R3 blank");
    step(1'b1, 1'b1, 1'b1); check_all("R8 back to video");
  endtask

  task automatic t_sync_routing_r4_r5();
    for (int m = 0; m < 8; m++) begin
      en_r = m[0]; en_g = m[1]; en_b = m[2]; tri_en = 1'b1;
      step(1'b0, 1'b0, 1'b0); check_all("R4 sync over tri and blank");
      step(1'b0, 1'b1, 1'b1); check_all("R5 sync per channel");
    end
  endtask

  task automatic t_sync_ignored_r5();
    en_r = 1'b0; en_g = 1'b0; en_b = 1'b0; tri_en = 1'b1;
    step(1'b0, 1'b1, 1'b1);
    check("R5 red ignored", lvl_r, 2'b00);
    check("R5 green ignored", lvl_g, 2'b00);
    check("R5 blue ignored", lvl_b, 2'b00);
    step(1'b0, 1'b0, 1'b0);
    check("R5 blue blank only", lvl_b, 2'b01);
  endtask

  task automatic t_trisync_r6_r7();
    en_r = 1'b1; en_g = 1'b0; en_b = 1'b1; tri_en = 1'b1;
    step(1'b1, 1'b0, 1'b1);
    check("R6 red tri", lvl_r, 2'b11);
    check("R6 green not enabled", lvl_g, 2'b00);
    step(1'b1, 1'b0, 1'b0);
    check("R6 blue tri over blank", lvl_b, 2'b11);
    check("R6 green blank", lvl_g, 2'b01);
    tri_en = 1'b0;
    step(1'b1, 1'b0, 1'b1);
    check("R7 red tri disabled", lvl_r, 2'b00);
    check("R7 blue tri disabled", lvl_b, 2'b00);
    step(1'b1, 1'b0, 1'b0);
    check("R7 red blank", lvl_r, 2'b01);
  endtask

  task automatic t_delay_r9();
    logic pat [24];
    logic exp_v;
    en_r = 1'b0; en_g = 1'b0; en_b = 1'b0; tri_en = 1'b0;
    for (int k = 0; k < 24; k++)
      pat[k] = !(k == 2 || k == 5 || k == 6 || k == 10 || k == 11 || k == 12 ||
                 k == 13 || k == 14 || k == 18 || k == 21);
    for (int k = 0; k < PIPE_DEPTH; k++) step(1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 24; k++) begin
      step(pat[k], 1'b1, 1'b1);
      exp_v = (k >= PIPE_DEPTH - 1) ? pat[k - PIPE_DEPTH + 1] : 1'b1;
      check("R9 delayed sync", {1'b0, sync_out_n}, {1'b0, exp_v});
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset_r1();
    t_video_blank_r2_r3();
    t_sync_routing_r4_r5();
    t_sync_ignored_r5();
    t_trisync_r6_r7();
    t_delay_r9();
    done = 1'b1;
  end

  initial begin
    for (int w = 0; w < 5000; w++) begin
      if (done) break;
      @(posedge clk);
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule